// File: doc/BRIEF.md
# Paired Down-Counting Event Timer

This block holds two independent 32-bit counters that step down by one on every clock while enabled. Software reaches them through a small register window driven by single-cycle read and write strobes. A channel runs in one of two modes. In one-shot mode it counts down from a value software wrote and raises a single expiry event. In auto-reload mode it refills from a per-channel reload register every time it leaves zero, so it works as a periodic tick or as a free-running time base.

Each expiry latches a per-channel pending bit. A per-channel enable mask decides which pending bits reach the single registered interrupt line. Software acknowledges one channel at a time by writing zero to that channel's pending bit, and it can start a new one-shot delay by rewriting the live count while the channel keeps running.

The register window uses byte offsets and a 6-bit address:

- Control is at 0x00.
- Channel c has its reload register at 0x10+8c and its live count at 0x14+8c.
- The pending register is at 0x20 and the interrupt mask at 0x24.

Top module: `countdown_timer_pair`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: A write at 0x00 sets the control bits: bit 2c is the run enable of channel c and bit 2c+1 is its reload enable. The reload registers, live counts, pending bits and mask bits read back at the offsets above. Read data appears on the clock after the read strobe, shows the state before that edge, and holds while no read is strobed. An unmapped offset reads zero.
- R3: While a channel is enabled its count drops by exactly one per clock, so 0xFFFFFFFF minus a value read from a count started at 0xFFFFFFFF equals the number of elapsed clocks.
- R4: Clearing a channel's run enable freezes its count. Setting it again resumes counting from the frozen value.
- R5: With reload enabled, a channel leaving zero takes its reload value. Writing N to both the reload and the count gives a period of N+1 clocks.
- R6: With reload disabled, the count stops at zero and expires once only, until the count register is written again.
- R7: A write to a count register loads it on that edge, overriding counting, so a new delay starts without stopping the channel.
- R8: An expiry (the clock on which an enabled channel's count leaves zero) sets that channel's pending bit on the same edge.
- R9: A write at 0x20 clears each pending bit whose data bit is 0 and keeps each bit whose data bit is 1. An expiry in the same cycle wins over the clear.
- R10: `irq_o` is a register that goes high one clock after any pending bit with its mask bit set is 1.
- R11: A pending bit whose mask bit (bit c at 0x24) is 0 never drives `irq_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; counters step once per rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Single-cycle write strobe |
| rd_en_i | input | 1 | Single-cycle read strobe |
| addr_i | input | 6 | Byte offset of the register accessed |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Registered read data |
| irq_o | output | 1 | Registered interrupt request |

## Verification
A write takes effect on the edge that samples its strobe. A read returns the state from before its own edge, one clock later. A one-shot loaded with N reaches zero N edges after the load edge and sets its pending bit on edge N+1. The interrupt line follows one edge after that. The bench drives every strobe just after a falling edge and samples `irq_o` and `rd_data_o` on the following falling edges. It counts the edges that pass between stimulus and sample, so each expected count, pending pattern and interrupt level is compared on exactly the clock it is due.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int unsigned TMR_ADDR_W = 6;
  localparam int unsigned CTRL_OFF   = 0;

  // per-channel register offsets, 8 bytes apart from 0x10
  function automatic int unsigned reload_off(int unsigned ch);
    return 16 + 8 * ch;
  endfunction

  function automatic int unsigned count_off(int unsigned ch);
    return 20 + 8 * ch;
  endfunction

  // pending and mask registers follow the last channel
  function automatic int unsigned pend_off(int unsigned num_ch);
    return 16 + 8 * num_ch;
  endfunction

  function automatic int unsigned mask_off(int unsigned num_ch);
    return 20 + 8 * num_ch;
  endfunction

endpackage

// File: rtl/tmr_regif.sv
module tmr_regif #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 6
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic                           rd_en_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [DATA_W-1:0]              wr_data_i,
  output logic [2*NUM_CH-1:0]            ctrl_o,
  output logic [NUM_CH-1:0]              reload_wr_o,
  output logic [NUM_CH-1:0]              count_wr_o,
  output logic                           pend_wr_o,
  output logic                           mask_wr_o,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  reload_q_i,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  count_q_i,
  input  logic [NUM_CH-1:0]              pend_q_i,
  input  logic [NUM_CH-1:0]              mask_q_i,
  output logic [DATA_W-1:0]              rd_data_o
);
  localparam int unsigned CTRL_W = 2 * NUM_CH;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(tmr_pkg::CTRL_OFF);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(tmr_pkg::pend_off(NUM_CH));
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(tmr_pkg::mask_off(NUM_CH));

  logic [DATA_W-1:0] rd_mux;
  logic              ctrl_wr;

  assign ctrl_wr   = wr_en_i && (addr_i == A_CTRL);
  assign pend_wr_o = wr_en_i && (addr_i == A_PEND);
  assign mask_wr_o = wr_en_i && (addr_i == A_MASK);

  always_comb begin
    reload_wr_o = '0;
    count_wr_o  = '0;
    for (int unsigned ch = 0; ch < NUM_CH; ch++) begin
      reload_wr_o[ch] = wr_en_i && (addr_i == ADDR_W'(tmr_pkg::reload_off(ch)));
      count_wr_o[ch]  = wr_en_i && (addr_i == ADDR_W'(tmr_pkg::count_off(ch)));
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr_i == A_CTRL) rd_mux = DATA_W'(ctrl_o);
    if (addr_i == A_PEND) rd_mux = DATA_W'(pend_q_i);
    if (addr_i == A_MASK) rd_mux = DATA_W'(mask_q_i);
    for (int unsigned ch = 0; ch < NUM_CH; ch++) begin
      if (addr_i == ADDR_W'(tmr_pkg::reload_off(ch))) rd_mux = reload_q_i[ch];
      if (addr_i == ADDR_W'(tmr_pkg::count_off(ch)))  rd_mux = count_q_i[ch];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o    <= '0;
      rd_data_o <= '0;
    end else begin
      if (ctrl_wr) ctrl_o <= wr_data_i[CTRL_W-1:0];
      if (rd_en_i) rd_data_o <= rd_mux;
    end
  end

  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o)); // R2

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_en_i,
  input  logic             reload_en_i,
  input  logic             reload_wr_i,
  input  logic             count_wr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] reload_q_o,
  output logic [CNT_W-1:0] count_q_o,
  output logic             expire_o
);
  logic armed_q;
  logic at_zero;

  // next live count: load beats counting, zero refills or rests
  function automatic logic [CNT_W-1:0] next_count(
    input logic [CNT_W-1:0] cur,
    input logic [CNT_W-1:0] refill,
    input logic             run,
    input logic             rld,
    input logic             load,
    input logic [CNT_W-1:0] load_val
  );
    if (load)          return load_val;
    if (!run)          return cur;
    if (cur == '0)     return rld ? refill : '0;
    return cur - CNT_W'(1);
  endfunction

  assign at_zero  = (count_q_o == '0);
  assign expire_o = run_en_i && at_zero && !count_wr_i && (reload_en_i || armed_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q_o  <= '0;
      reload_q_o <= '0;
      armed_q    <= 1'b0;
    end else begin
      count_q_o <= next_count(count_q_o, reload_q_o, run_en_i, reload_en_i,
                              count_wr_i, wr_data_i);
      if (reload_wr_i) reload_q_o <= wr_data_i;
      if (count_wr_i)                     armed_q <= 1'b1;
      else if (expire_o && !reload_en_i)  armed_q <= 1'b0;
    end
  end

  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_en_i && !count_wr_i && !at_zero |=> count_q_o == $past(count_q_o) - CNT_W'(1)); // R3
  AST_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_en_i && !count_wr_i |=> $stable(count_q_o)); // R4
  AST_REFILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o && reload_en_i |=> count_q_o == $past(reload_q_o)); // R5
  AST_REST_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_en_i && !reload_en_i && at_zero && !count_wr_i |=> at_zero); // R6
  AST_SINGLE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o && !reload_en_i |=> !expire_o || reload_en_i); // R6
  AST_LOAD_NOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_wr_i |=> count_q_o == $past(wr_data_i)); // R7

endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
  parameter int unsigned NUM_CH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] expire_i,
  input  logic              pend_wr_i,
  input  logic              mask_wr_i,
  input  logic [NUM_CH-1:0] wr_bits_i,
  output logic [NUM_CH-1:0] pend_q_o,
  output logic [NUM_CH-1:0] mask_q_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0] pend_kept;
  logic [NUM_CH-1:0] live_req;

  // zero bits acknowledge, one bits keep; new expiries always land
  assign pend_kept = pend_wr_i ? (pend_q_o & wr_bits_i) : pend_q_o;
  assign live_req  = pend_q_o & mask_q_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q_o <= '0;
      mask_q_o <= '0;
      irq_o    <= 1'b0;
    end else begin
      pend_q_o <= pend_kept | expire_i;
      if (mask_wr_i) mask_q_o <= wr_bits_i;
      irq_o <= |live_req;
    end
  end

  AST_PEND_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i != '0) |=> (pend_q_o & $past(expire_i)) == $past(expire_i)); // R8
  AST_ACK_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_wr_i && (expire_i == '0) |=> pend_q_o == ($past(pend_q_o) & $past(wr_bits_i))); // R9
  AST_IRQ_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_req != '0) |=> irq_o); // R10
  AST_MASKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_req == '0) |=> !irq_o); // R11

endmodule

// File: rtl/countdown_timer_pair.sv
module countdown_timer_pair #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned CNT_W  = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic                          rd_en_i,
  input  logic [tmr_pkg::TMR_ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]              wr_data_i,
  output logic [CNT_W-1:0]              rd_data_o,
  output logic                          irq_o
);
  localparam int unsigned ADDR_W = tmr_pkg::TMR_ADDR_W;
  localparam int unsigned CTRL_W = 2 * NUM_CH;

  logic [CTRL_W-1:0]            ctrl_q;
  logic [NUM_CH-1:0]            reload_wr;
  logic [NUM_CH-1:0]            count_wr;
  logic                         pend_wr;
  logic                         mask_wr;
  logic [NUM_CH-1:0][CNT_W-1:0] reload_q;
  logic [NUM_CH-1:0][CNT_W-1:0] count_q;
  logic [NUM_CH-1:0]            expire;
  logic [NUM_CH-1:0]            pend_q;
  logic [NUM_CH-1:0]            mask_q;

  tmr_regif #(
    .NUM_CH (NUM_CH),
    .DATA_W (CNT_W),
    .ADDR_W (ADDR_W)
  ) regif_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .rd_en_i     (rd_en_i),
    .addr_i      (addr_i),
    .wr_data_i   (wr_data_i),
    .ctrl_o      (ctrl_q),
    .reload_wr_o (reload_wr),
    .count_wr_o  (count_wr),
    .pend_wr_o   (pend_wr),
    .mask_wr_o   (mask_wr),
    .reload_q_i  (reload_q),
    .count_q_i   (count_q),
    .pend_q_i    (pend_q),
    .mask_q_i    (mask_q),
    .rd_data_o   (rd_data_o)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    tmr_channel #(.CNT_W(CNT_W)) chan_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .run_en_i    (ctrl_q[2*ch]),
      .reload_en_i (ctrl_q[2*ch+1]),
      .reload_wr_i (reload_wr[ch]),
      .count_wr_i  (count_wr[ch]),
      .wr_data_i   (wr_data_i),
      .reload_q_o  (reload_q[ch]),
      .count_q_o   (count_q[ch]),
      .expire_o    (expire[ch])
    );
  end

  tmr_irq #(.NUM_CH(NUM_CH)) irq_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .expire_i  (expire),
    .pend_wr_i (pend_wr),
    .mask_wr_i (mask_wr),
    .wr_bits_i (wr_data_i[NUM_CH-1:0]),
    .pend_q_o  (pend_q),
    .mask_q_o  (mask_q),
    .irq_o     (irq_o)
  );

endmodule

// File: tb/countdown_timer_pair_tb.sv
module countdown_timer_pair_tb_top;

  localparam logic [5:0] A_CTRL = 6'h00;
  localparam logic [5:0] A_RLD0 = 6'h10;
  localparam logic [5:0] A_CNT0 = 6'h14;
  localparam logic [5:0] A_RLD1 = 6'h18;
  localparam logic [5:0] A_CNT1 = 6'h1C;
  localparam logic [5:0] A_PEND = 6'h20;
  localparam logic [5:0] A_MASK = 6'h24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  countdown_timer_pair dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .rd_en_i   (rd_en),
    .addr_i    (addr),
    .wr_data_i (wdata),
    .rd_data_o (rdata),
    .irq_o     (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd(A_CTRL, v); chk("R1 ctrl", v, 32'h0);
    rd(A_CNT1, v); chk("R1 count1", v, 32'h0);
    rd(A_PEND, v); chk("R1 pending", v, 32'h0);
    rd(6'h08, v);  chk("R2 unmapped", v, 32'h0);
  endtask

  task automatic t_regmap();
    logic [31:0] v;
    do_reset();
    wr(A_RLD0, 32'h1111_1111);
    wr(A_RLD1, 32'h2222_2222);
    wr(A_CNT0, 32'h3333_3333);
    wr(A_CNT1, 32'h4444_4444);
    wr(A_MASK, 32'h3);
    wr(A_CTRL, 32'hA);
    rd(A_RLD0, v); chk("R2 reload0", v, 32'h1111_1111);
    rd(A_RLD1, v); chk("R2 reload1", v, 32'h2222_2222);
    rd(A_CNT0, v); chk("R2 count0", v, 32'h3333_3333);
    rd(A_CNT1, v); chk("R2 count1", v, 32'h4444_4444);
    rd(A_MASK, v); chk("R2 mask", v, 32'h3);
    rd(A_CTRL, v); chk("R2 ctrl", v, 32'hA);
    repeat (3) @(negedge clk);
    chk("R2 read hold", rdata, 32'hA);
  endtask

  task automatic t_elapsed();
    logic [31:0] v;
    do_reset();
    wr(A_RLD0, 32'hFFFF_FFFF);
    wr(A_CNT0, 32'hFFFF_FFFF);
    wr(A_CTRL, 32'h3);
    repeat (20) @(negedge clk);
    rd(A_CNT0, v);
    chk("R3 elapsed", 32'hFFFF_FFFF - v, 32'd20);
  endtask

  task automatic t_freeze();
    logic [31:0] v;
    do_reset();
    wr(A_CNT0, 32'd50);
    wr(A_CTRL, 32'h1);
    repeat (9) @(negedge clk);
    wr(A_CTRL, 32'h0);
    rd(A_CNT0, v); chk("R4 frozen", v, 32'd40);
    repeat (5) @(negedge clk);
    rd(A_CNT0, v); chk("R4 still frozen", v, 32'd40);
    wr(A_CTRL, 32'h1);
    rd(A_CNT0, v); chk("R4 resume point", v, 32'd40);
    rd(A_CNT0, v); chk("R4 resumed", v, 32'd39);
  endtask

  task automatic t_reload();
    logic [31:0] v;
    int bad = 0;
    do_reset();
    wr(A_RLD0, 32'd4);
    wr(A_CNT0, 32'd4);
    wr(A_CTRL, 32'h3);
    for (int i = 0; i < 10; i++) begin
      rd(A_CNT0, v);
      if (v !== 32'(4 - (i % 5))) begin
        bad++;
        $display("FAIL R5 step %0d actual=%h expected=%h", i, v, 32'(4 - (i % 5)));
      end
    end
    n_chk++;
    if (bad != 0) n_err++;
  endtask

  task automatic t_oneshot();
    logic [31:0] v;
    int hi = 0;
    do_reset();
    wr(A_MASK, 32'h2);
    wr(A_CTRL, 32'h4);
    wr(A_CNT1, 32'd3);
    repeat (4) begin
      @(negedge clk);
      if (irq) hi++;
    end
    chk("R10 no early irq", 32'(hi), 32'd0);
    @(negedge clk);
    chk("R8 R10 irq after expiry", {31'b0, irq}, 32'h1);
    rd(A_PEND, v); chk("R8 pending", v, 32'h2);
    rd(A_CNT1, v); chk("R6 rests at zero", v, 32'h0);
    wr(A_PEND, 32'h0);
    @(negedge clk);
    chk("R9 ack drops irq", {31'b0, irq}, 32'h0);
    hi = 0;
    repeat (10) begin
      @(negedge clk);
      if (irq) hi++;
    end
    chk("R6 single expiry", 32'(hi), 32'd0);
    rd(A_PEND, v); chk("R6 no new pending", v, 32'h0);
  endtask

  task automatic t_restart();
    int hi = 0;
    do_reset();
    wr(A_MASK, 32'h2);
    wr(A_CTRL, 32'h4);
    wr(A_CNT1, 32'd100);
    repeat (5) @(negedge clk);
    wr(A_CNT1, 32'd2);
    repeat (3) begin
      @(negedge clk);
      if (irq) hi++;
    end
    chk("R7 no irq before reload delay", 32'(hi), 32'd0);
    @(negedge clk);
    chk("R7 irq from new delay", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    int hi = 0;
    do_reset();
    wr(A_RLD0, 32'd2); wr(A_CNT0, 32'd2);
    wr(A_RLD1, 32'd3); wr(A_CNT1, 32'd3);
    wr(A_CTRL, 32'hF);
    repeat (20) begin
      @(negedge clk);
      if (irq) hi++;
    end
    chk("R11 masked quiet", 32'(hi), 32'd0);
    rd(A_PEND, v); chk("R11 pending still set", v, 32'h3);
    wr(A_CTRL, 32'h0);
    wr(A_PEND, 32'h2);
    rd(A_PEND, v); chk("R9 selective ack", v, 32'h2);
    wr(A_MASK, 32'h2);
    chk("R10 irq registered", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R10 irq on unmask", {31'b0, irq}, 32'h1);
    wr(A_MASK, 32'h1);
    @(negedge clk);
    chk("R11 irq off when masked", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    t_reset();
    t_regmap();
    t_elapsed();
    t_freeze();
    t_reload();
    t_oneshot();
    t_restart();
    t_mask();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule